// File: doc/BRIEF.md
# Configuration Retry-Status Completion Handler

This block sits inside a PCIe root port, between the path that sends configuration read requests towards an endpoint and the path that returns read data to the host. The host hands it one configuration read at a time (a tag and a register offset). The block forwards the request, takes the matching completion (status code and 32-bit data), and returns a response to the host with the data chosen by the completion status. It only substitutes data when the status says the endpoint is not ready yet (retry status) or when the read failed.

Retry-status completions follow a software-visibility enable bit taken from the root control register. With visibility on, a retry-status answer to a Vendor ID read comes back as a recognisable invalid ID, and any other read fails with all-ones. With visibility off, the block flags a retry event to the port. Then it either fails the read with all-ones or, in automatic mode, sends the same request again, up to a programmable number of times. Link layer, packet formation and multi-request tracking are outside the block; every boundary is a plain valid/ready pair.

Top module: `crs_cpl_handler`

## Requirements
- R1: A completion with status 0 (successful) returns its data unchanged with response status 0 and the retry flag low.
- R2: With visibility enabled, a completion with status 2 (retry) for a read of offset 0 returns 0xFFFF0001 with response status 0.
- R3: With visibility enabled, a status-2 completion for a read of any non-zero offset returns 0xFFFFFFFF with response status 1 (failed).
- R4: With visibility enabled, the retry event output never rises, the response retry flag stays low, no response carries status 2, and no request is reissued.
- R5: With visibility disabled, a status-2 completion raises the retry event output in the same cycle as the completion handshake (cplValid and cplReady both high).
- R6: With visibility disabled and automatic reissue off, a status-2 completion is not reissued: the response is 0xFFFFFFFF with status 2 and the retry flag high. The value 0xFFFF0001 is never produced.
- R7: With visibility disabled and automatic reissue on, each status-2 completion sends the same tag and offset out again, as long as fewer than maxRetry reissues have been made. The completion that ends the sequence decides the response.
- R8: When a status-2 completion arrives after maxRetry reissues (including maxRetry = 0), the request fails with 0xFFFFFFFF, status 2 and the retry flag high. In total, maxRetry+1 requests go out.
- R9: Completions with status 1 (unsupported request) or 4 (completer abort) return 0xFFFFFFFF, forward their status code and keep the retry flag low.
- R10: While rspValid is high and rspReady low, the response tag, data, status and retry flag hold their values.
- R11: After reset, and again after each response is accepted, only reqReady is high. From request acceptance to response acceptance, exactly one of reqReady, outValid, cplReady and rspValid is high, and it is never reqReady.
- R12: Forwarded requests and the response carry the tag and offset accepted from the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| visEnable | input | 1 | Retry-status software visibility enable |
| autoRetry | input | 1 | Reissue on retry status when visibility is off |
| maxRetry | input | CNT_W | Maximum number of reissues per request |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Host request accepted |
| reqTag | input | TAG_W | Host request tag |
| reqOffset | input | OFF_W | Configuration register byte offset |
| outValid | output | 1 | Forwarded request valid |
| outReady | input | 1 | Forwarded request accepted |
| outTag | output | TAG_W | Forwarded request tag |
| outOffset | output | OFF_W | Forwarded request offset |
| cplValid | input | 1 | Completion valid |
| cplReady | output | 1 | Completion accepted |
| cplStatus | input | 3 | Completion status code |
| cplData | input | DATA_W | Completion data |
| crsEvent | output | 1 | Retry-status event, visibility off |
| rspValid | output | 1 | Host response valid |
| rspReady | input | 1 | Host response accepted |
| rspTag | output | TAG_W | Response tag |
| rspData | output | DATA_W | Response data |
| rspStatus | output | 3 | Response status code |
| rspRetry | output | 1 | Response ended in retry status |

## Verification
The assertions assume that visEnable, autoRetry and maxRetry stay constant while a request is in flight, and that each completion belongs to the single outstanding request. The stimulus changes the mode inputs only between transactions, when the response has been accepted and reqReady is high again. It offers a completion only after the forwarded request has been accepted. It holds back rspReady for zero to two cycles so that the held-response rule is exercised.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam logic [2:0] ST_SC  = 3'd0;
  localparam logic [2:0] ST_UR  = 3'd1;
  localparam logic [2:0] ST_CRS = 3'd2;
  localparam logic [2:0] ST_CA  = 3'd4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic latchReq;
    logic latchRsp;
  } strobes_t;
endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             visEnable,
  input  logic             autoRetry,
  input  logic [CNT_W-1:0] maxRetry,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             outValid,
  input  logic             outReady,
  input  logic             cplValid,
  output logic             cplReady,
  input  logic             cplIsCrs,
  output logic             rspValid,
  input  logic             rspReady,
  output logic             crsEvent,
  output strobes_t         strobes
);
  phase_e phase, phaseNext;
  logic [CNT_W-1:0] retryCnt;
  logic cplTake, crsHidden, reissue;

  always_comb begin
    reqReady  = (phase == S_IDLE);
    outValid  = (phase == S_ISSUE);
    cplReady  = (phase == S_WAIT);
    rspValid  = (phase == S_RESP);
    cplTake   = cplValid && cplReady;
    crsHidden = cplTake && cplIsCrs && !visEnable;
    crsEvent  = crsHidden;
    reissue   = crsHidden && autoRetry && (retryCnt < maxRetry);
    strobes.latchReq = reqValid && reqReady;
    strobes.latchRsp = cplTake && !reissue;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      S_IDLE:  if (reqValid) phaseNext = S_ISSUE;
      S_ISSUE: if (outReady) phaseNext = S_WAIT;
      S_WAIT:  if (cplTake)  phaseNext = reissue ? S_ISSUE : S_RESP;
      S_RESP:  if (rspReady) phaseNext = S_IDLE;
      default: phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= S_IDLE;
      retryCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (strobes.latchReq) retryCnt <= '0;
      else if (reissue)     retryCnt <= retryCnt + 1'b1;
    end
  end
endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              visEnable,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [2:0]        cplStatus,
  input  logic [DATA_W-1:0] cplData,
  output logic              cplIsCrs,
  output logic [TAG_W-1:0]  outTag,
  output logic [OFF_W-1:0]  outOffset,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData,
  output logic [2:0]        rspStatus,
  output logic              rspRetry
);
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;
  localparam logic [DATA_W-1:0] VID_RETRY = {{(DATA_W-16){1'b1}}, 16'h0001};

  logic [TAG_W-1:0]  tagQ;
  logic [OFF_W-1:0]  offQ;
  logic              isVid;
  logic [DATA_W-1:0] dataNext;
  logic [2:0]        statusNext;
  logic              retryNext;

  always_comb begin
    cplIsCrs   = (cplStatus == ST_CRS);
    isVid      = (offQ == '0);
    dataNext   = ALL_ONES;
    statusNext = cplStatus;
    retryNext  = 1'b0;
    if (cplStatus == ST_SC) begin
      dataNext = cplData;
    end else if (cplIsCrs) begin
      if (visEnable) begin
        dataNext   = isVid ? VID_RETRY : ALL_ONES;
        statusNext = isVid ? ST_SC : ST_UR;
      end else begin
        retryNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ      <= '0;
      offQ      <= '0;
      rspTag    <= '0;
      rspData   <= '0;
      rspStatus <= ST_SC;
      rspRetry  <= 1'b0;
    end else begin
      if (strobes.latchReq) begin
        tagQ <= reqTag;
        offQ <= reqOffset;
      end
      if (strobes.latchRsp) begin
        rspTag    <= tagQ;
        rspData   <= dataNext;
        rspStatus <= statusNext;
        rspRetry  <= retryNext;
      end
    end
  end

  assign outTag    = tagQ;
  assign outOffset = offQ;
endmodule

// File: rtl/crs_cpl_handler.sv
module crs_cpl_handler
  import crs_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              visEnable,
  input  logic              autoRetry,
  input  logic [CNT_W-1:0]  maxRetry,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [OFF_W-1:0]  reqOffset,
  output logic              outValid,
  input  logic              outReady,
  output logic [TAG_W-1:0]  outTag,
  output logic [OFF_W-1:0]  outOffset,
  input  logic              cplValid,
  output logic              cplReady,
  input  logic [2:0]        cplStatus,
  input  logic [DATA_W-1:0] cplData,
  output logic              crsEvent,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData,
  output logic [2:0]        rspStatus,
  output logic              rspRetry
);
  strobes_t strobes;
  logic     cplIsCrs;

  crs_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .visEnable(visEnable), .autoRetry(autoRetry),
    .maxRetry(maxRetry), .reqValid(reqValid), .reqReady(reqReady),
    .outValid(outValid), .outReady(outReady), .cplValid(cplValid),
    .cplReady(cplReady), .cplIsCrs(cplIsCrs), .rspValid(rspValid),
    .rspReady(rspReady), .crsEvent(crsEvent), .strobes(strobes)
  );

  crs_datapath #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .visEnable(visEnable),
    .reqTag(reqTag), .reqOffset(reqOffset), .cplStatus(cplStatus),
    .cplData(cplData), .cplIsCrs(cplIsCrs), .outTag(outTag),
    .outOffset(outOffset), .rspTag(rspTag), .rspData(rspData),
    .rspStatus(rspStatus), .rspRetry(rspRetry)
  );
endmodule

// File: rtl/crs_cpl_checker.sv
module crs_cpl_checker #(
  parameter int TAG_W  = 8,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              visEnable,
  input logic              autoRetry,
  input logic [CNT_W-1:0]  maxRetry,
  input logic              reqValid,
  input logic              reqReady,
  input logic              outValid,
  input logic              outReady,
  input logic [TAG_W-1:0]  outTag,
  input logic [OFF_W-1:0]  outOffset,
  input logic              cplValid,
  input logic              cplReady,
  input logic [2:0]        cplStatus,
  input logic              crsEvent,
  input logic              rspValid,
  input logic              rspReady,
  input logic [TAG_W-1:0]  rspTag,
  input logic [DATA_W-1:0] rspData,
  input logic [2:0]        rspStatus,
  input logic              rspRetry
);
  logic [CNT_W:0] issuedCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) issuedCnt <= '0;
    else if (reqValid && reqReady) issuedCnt <= '0;
    else if (outValid && outReady) issuedCnt <= issuedCnt + 1'b1;
  end

  // R4
  vis_hides_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    visEnable |-> !crsEvent);

  // R4
  vis_no_retry_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && visEnable) |-> (!rspRetry && rspStatus != 3'd2));

  // R5
  crs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplReady && cplStatus == 3'd2 && !visEnable) |-> crsEvent);

  // R6
  fail_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspRetry) |-> (rspData == '1 && rspStatus == 3'd2));

  // R6
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (visEnable || !autoRetry)) |-> (issuedCnt == '0));

  // R8
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (issuedCnt <= {1'b0, maxRetry}));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspTag)
                                 && $stable(rspStatus) && $stable(rspRetry)));

  // R11
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, outValid, cplReady, rspValid}));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outTag) && $stable(outOffset)));
endmodule

bind crs_cpl_handler crs_cpl_checker #(
  .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) uChecker (
  .clk(clk), .rstN(rstN), .visEnable(visEnable), .autoRetry(autoRetry),
  .maxRetry(maxRetry), .reqValid(reqValid), .reqReady(reqReady),
  .outValid(outValid), .outReady(outReady), .outTag(outTag),
  .outOffset(outOffset), .cplValid(cplValid), .cplReady(cplReady),
  .cplStatus(cplStatus), .crsEvent(crsEvent), .rspValid(rspValid),
  .rspReady(rspReady), .rspTag(rspTag), .rspData(rspData),
  .rspStatus(rspStatus), .rspRetry(rspRetry)
);

// File: tb/tb_crs_cpl_handler.sv
`timescale 1ns/1ps
module tb_crs_cpl_handler;
  localparam int TAG_W = 8, OFF_W = 12, DATA_W = 32, CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic visEnable = 1'b0, autoRetry = 1'b0;
  logic [CNT_W-1:0] maxRetry = '0;
  logic reqValid = 1'b0, outReady = 1'b0, cplValid = 1'b0, rspReady;
  logic [TAG_W-1:0] reqTag = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [2:0] cplStatus = '0;
  logic [DATA_W-1:0] cplData = '0;
  logic reqReady, outValid, cplReady, crsEvent, rspValid, rspRetry;
  logic [TAG_W-1:0] outTag, rspTag;
  logic [OFF_W-1:0] outOffset;
  logic [DATA_W-1:0] rspData;
  logic [2:0] rspStatus;

  always #4 clk = ~clk;

  crs_cpl_handler #(.TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .visEnable(visEnable), .autoRetry(autoRetry),
    .maxRetry(maxRetry), .reqValid(reqValid), .reqReady(reqReady),
    .reqTag(reqTag), .reqOffset(reqOffset), .outValid(outValid),
    .outReady(outReady), .outTag(outTag), .outOffset(outOffset),
    .cplValid(cplValid), .cplReady(cplReady), .cplStatus(cplStatus),
    .cplData(cplData), .crsEvent(crsEvent), .rspValid(rspValid),
    .rspReady(rspReady), .rspTag(rspTag), .rspData(rspData),
    .rspStatus(rspStatus), .rspRetry(rspRetry)
  );

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    logic [2:0]        status;
    logic              retry;
  } rsp_t;

  rsp_t rspQ[$];
  int checks = 0, fails = 0, nRsp = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as responses appear, stalling ready 0..2 cycles
  initial begin
    bit seen;
    int stall;
    rsp_t held, got, exp;
    rspReady = 1'b0;
    seen = 1'b0;
    stall = 0;
    forever begin
      @(negedge clk);
      if (rspReady) begin
        rspReady = 1'b0;
        seen = 1'b0;
      end else if (rspValid) begin
        got = '{rspTag, rspData, rspStatus, rspRetry};
        if (!seen) begin
          seen = 1'b1;
          held = got;
          stall = nRsp % 3;
        end else begin
          check(got == held, "R10 held response", 64'(got), 64'(held));
        end
        if (stall == 0) begin
          if (rspQ.size() == 0) begin
            check(1'b0, "R11 unexpected response", 64'(got), 64'h0);
          end else begin
            exp = rspQ.pop_front();
            check(got.tag == exp.tag, "R12 response tag", 64'(got.tag), 64'(exp.tag));
            check(got.data == exp.data, "R1-R9 response data", 64'(got.data), 64'(exp.data));
            check(got.status == exp.status, "response status", 64'(got.status), 64'(exp.status));
            check(got.retry == exp.retry, "response retry flag", 64'(got.retry), 64'(exp.retry));
          end
          rspReady = 1'b1;
          nRsp++;
        end else begin
          stall--;
        end
      end
    end
  end

  // Driver: one transaction; endpoint answers nCrs retry statuses, then finalSt
  task automatic runTxn(input string req, input logic vis, input logic autoR,
                        input int maxR, input logic [TAG_W-1:0] tag,
                        input logic [OFF_W-1:0] off, input int nCrs,
                        input logic [2:0] finalSt, input logic [DATA_W-1:0] data);
    int issues;
    logic [2:0] seenSt;
    rsp_t exp;
    if (!vis && autoR) begin
      issues = (nCrs <= maxR) ? nCrs + 1 : maxR + 1;
      seenSt = (nCrs <= maxR) ? finalSt : 3'd2;
    end else begin
      issues = 1;
      seenSt = (nCrs > 0) ? 3'd2 : finalSt;
    end
    exp.tag = tag;
    exp.retry = 1'b0;
    exp.data = 32'hFFFF_FFFF;
    exp.status = seenSt;
    if (seenSt == 3'd0) exp.data = data;
    else if (seenSt == 3'd2) begin
      if (vis) begin
        exp.data = (off == 0) ? 32'hFFFF_0001 : 32'hFFFF_FFFF;
        exp.status = (off == 0) ? 3'd0 : 3'd1;
      end else exp.retry = 1'b1;
    end
    rspQ.push_back(exp);

    @(negedge clk);
    visEnable = vis; autoRetry = autoR; maxRetry = CNT_W'(maxR);
    check(reqReady == 1'b1, {req, " R11 idle ready"}, 64'(reqReady), 64'h1);
    reqValid = 1'b1; reqTag = tag; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, {req, " R11 busy"}, 64'(reqReady), 64'h0);
    for (int a = 0; a < issues; a++) begin
      while (!outValid) @(negedge clk);
      check(outTag == tag && outOffset == off, {req, " R7 R12 forwarded tag/offset"},
            64'({outTag, outOffset}), 64'({tag, off}));
      outReady = 1'b1;
      @(negedge clk);
      outReady = 1'b0;
      cplValid = 1'b1;
      cplStatus = (a < nCrs) ? 3'd2 : finalSt;
      cplData = data;
      #1;
      check(cplReady == 1'b1, {req, " R11 completion ready"}, 64'(cplReady), 64'h1);
      check(crsEvent == (cplStatus == 3'd2 && !vis), {req, " R4 R5 retry event"},
            64'(crsEvent), 64'(cplStatus == 3'd2 && !vis));
      @(negedge clk);
      cplValid = 1'b0;
    end
    while (rspQ.size() != 0 || rspValid || rspReady) begin
      if (outValid) check(1'b0, {req, " R6 R8 extra reissue"}, 64'h1, 64'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && !outValid && !cplReady && !rspValid && !crsEvent,
          "R11 reset state", 64'({reqReady, outValid, cplReady, rspValid, crsEvent}), 64'h10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1 && !outValid && !cplReady && !rspValid,
          "R11 after reset", 64'({reqReady, outValid, cplReady, rspValid}), 64'h8);
    runTxn("R1",  1'b1, 1'b0, 0, 8'h11, 12'h000, 0, 3'd0, 32'h10EE_1234);
    runTxn("R2",  1'b1, 1'b0, 0, 8'h12, 12'h000, 1, 3'd0, 32'h0);
    runTxn("R3",  1'b1, 1'b0, 0, 8'h13, 12'h004, 1, 3'd0, 32'h0);
    runTxn("R4",  1'b1, 1'b1, 3, 8'h14, 12'h000, 1, 3'd0, 32'h0);
    runTxn("R6",  1'b0, 1'b0, 3, 8'h15, 12'h000, 1, 3'd0, 32'h5555_AAAA);
    runTxn("R5",  1'b0, 1'b0, 0, 8'h16, 12'h008, 1, 3'd0, 32'h0);
    runTxn("R7",  1'b0, 1'b1, 3, 8'h17, 12'h010, 2, 3'd0, 32'hCAFE_0001);
    runTxn("R7b", 1'b0, 1'b1, 3, 8'h18, 12'h000, 3, 3'd0, 32'h1234_5678);
    runTxn("R8",  1'b0, 1'b1, 3, 8'h19, 12'h000, 5, 3'd0, 32'h0);
    runTxn("R8b", 1'b0, 1'b1, 0, 8'h1A, 12'h00C, 1, 3'd0, 32'h0);
    runTxn("R9",  1'b0, 1'b0, 0, 8'h1B, 12'h000, 0, 3'd1, 32'h9999_9999);
    runTxn("R9b", 1'b1, 1'b0, 0, 8'h1C, 12'h020, 0, 3'd4, 32'h7777_7777);
    runTxn("R7c", 1'b0, 1'b1, 2, 8'h1D, 12'h000, 1, 3'd1, 32'h0);
    runTxn("R1b", 1'b0, 1'b1, 2, 8'h1E, 12'h0FC, 0, 3'd0, 32'hFFFF_0001);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule